// File: doc/BRIEF.md
# Bidirectional Serial Shift Register with Direction Select

This block is a small shift register whose stages move together on one shift strobe. A single direction bit, sampled on the same edge as the strobe, decides which way the contents move. It also decides which of two serial inputs supplies the new bit. Moving toward the last stage, the new bit enters at stage 0 from the right-going serial input. Moving toward stage 0, the new bit enters at the last stage from the left-going serial input.

The width is a parameter and defaults to four stages. Output bit 0 is the first stage and bit WIDTH-1 is the last. A strobe that is low leaves the register untouched. An active-low reset clears it at once, and the block leaves reset in step with the clock through an internal two-flop release.

Top module: `bidir_shift_reg`

## Requirements
- R1: With dir_mode = 0 and shift_en = 1 at a rising edge, stage 0 takes ser_right_in and every stage i > 0 takes the old value of stage i-1.
- R2: With dir_mode = 0 and ser_right_in held at 1, four shifts leave all four stages at 1, whatever they held before.
- R3: With dir_mode = 1 and shift_en = 1 at a rising edge, stage WIDTH-1 takes ser_left_in and every stage i < WIDTH-1 takes the old value of stage i+1.
- R4: With dir_mode = 1 and ser_left_in held at 1, four shifts leave all four stages at 1, whatever they held before.
- R5: At a rising edge with shift_en = 0, q keeps its value, whatever dir_mode and the serial inputs do.
- R6: dir_mode matters only at the edges where shift_en = 1. A change of dir_mode between shifts steers only the next shift.
- R7: arst_n = 0 clears q to 0 without waiting for a clock edge. After arst_n rises, the strobe is ignored on the first two rising edges, and the first shift can happen on the third.
- R8: The serial input of the direction that is not selected has no effect on q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| arst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| dir_mode | input | 1 | 0 = move toward the last stage, 1 = move toward stage 0 |
| ser_right_in | input | 1 | Serial bit that enters stage 0 when dir_mode = 0 |
| ser_left_in | input | 1 | Serial bit that enters the last stage when dir_mode = 1 |
| shift_en | input | 1 | One-cycle shift strobe |
| q | output | WIDTH | Stage contents, bit 0 = first stage |

## Verification
The assertions take for granted that every input is steady around the rising edge. They also assume that nothing is expected to move while the internal reset release is still low. For that reason every clocked property is disabled until the synchronised release goes high. The bench changes all inputs on the falling edge and samples q on the falling edge after each shift. It drops the strobe whenever it toggles dir_mode or the serial inputs to test holding, so each edge sees one well-defined command.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic {
    DIR_TOWARD_LAST  = 1'b0,
    DIR_TOWARD_FIRST = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/bsr_next_state.sv
module bsr_next_state
  import bsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  shift_dir_e       dir,
  input  logic             ser_right_in,
  input  logic             ser_left_in,
  input  logic [WIDTH-1:0] cur_q,
  output logic [WIDTH-1:0] nxt_q
);
  localparam int LAST = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_lower;
    logic from_upper;
    if (i == 0) begin : g_first
      assign from_lower = ser_right_in;
    end else begin : g_mid_lo
      assign from_lower = cur_q[i-1];
    end
    if (i == LAST) begin : g_last
      assign from_upper = ser_left_in;
    end else begin : g_mid_hi
      assign from_upper = cur_q[i+1];
    end
    always_comb begin
      if (dir == DIR_TOWARD_FIRST) nxt_q[i] = from_upper;
      else                         nxt_q[i] = from_lower;
    end
  end
endmodule

// File: rtl/bsr_stage_reg.sv
module bsr_stage_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             dir_mode,
  input  logic             ser_right_in,
  input  logic             ser_left_in,
  input  logic             shift_en,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = WIDTH - 1;

  logic             rst_sync_n;
  logic [WIDTH-1:0] nxt_q;
  shift_dir_e       dir;

  assign dir = shift_dir_e'(dir_mode);

  bsr_rst_sync u_rst_sync (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsr_next_state #(.WIDTH(WIDTH)) u_next (
    .dir          (dir),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .cur_q        (q),
    .nxt_q        (nxt_q)
  );

  bsr_stage_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (shift_en),
    .d     (nxt_q),
    .q     (q)
  );

  // R1: move toward the last stage
  p_right_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !dir_mode) |=>
      (q[0] == $past(ser_right_in)) && (q[LAST:1] == $past(q[LAST-1:0])));

  // R3: move toward the first stage
  p_left_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && dir_mode) |=>
      (q[LAST] == $past(ser_left_in)) && (q[LAST-1:0] == $past(q[LAST:1])));

  // R5: hold while the strobe is low
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !shift_en |=> $stable(q));

  // R7: register is clear while the release is pending
  p_reset_r7: assert property (@(posedge clk)
    !rst_sync_n |-> (q == '0));
endmodule

// File: tb/test_bidir_shift_reg.sv
module test_bidir_shift_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         arst_n = 1'b0;
  logic         dir_mode = 1'b0;
  logic         ser_right_in = 1'b0;
  logic         ser_left_in = 1'b0;
  logic         shift_en = 1'b0;
  logic [W-1:0] q;
  logic [W-1:0] exp_q;
  int           checks = 0;
  int           failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) i_bidir_shift_reg (
    .clk          (clk),
    .arst_n       (arst_n),
    .dir_mode     (dir_mode),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .shift_en     (shift_en),
    .q            (q)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  // one shift; model from requirements R1 and R3
  task automatic do_shift(input logic m, input logic rin, input logic lin);
    @(negedge clk);
    dir_mode = m; ser_right_in = rin; ser_left_in = lin; shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    if (!m) exp_q = {exp_q[W-2:0], rin};
    else    exp_q = {lin, exp_q[W-1:1]};
  endtask

  task automatic t_reset_release;
    @(negedge clk);
    arst_n = 1'b0;
    #1 check("R7 async clear", q, '0);
    exp_q = '0;
    @(negedge clk);
    arst_n = 1'b1; dir_mode = 1'b0; ser_right_in = 1'b1; shift_en = 1'b1;
    @(negedge clk); check("R7 edge1 ignored", q, '0);
    @(negedge clk); check("R7 edge2 ignored", q, '0);
    @(negedge clk); check("R7 edge3 shifts", q, 4'b0001);
    shift_en = 1'b0;
    exp_q = 4'b0001;
  endtask

  task automatic t_right_walk;
    do_shift(1'b0, 1'b1, 1'b0); check("R1 walk a", q, exp_q);
    do_shift(1'b0, 1'b0, 1'b1); check("R1 walk b", q, exp_q);
    do_shift(1'b0, 1'b1, 1'b1); check("R1 walk c", q, exp_q);
    check("R1 pattern", q, 4'b1101);
  endtask

  task automatic t_right_fill;
    for (int k = 0; k < 4; k++) do_shift(1'b0, 1'b1, 1'b0);
    check("R2 fill ones", q, 4'b1111);
    for (int k = 0; k < 4; k++) do_shift(1'b0, 1'b0, 1'b1);
    check("R8 left input ignored in right mode", q, 4'b0000);
  endtask

  task automatic t_left_walk;
    do_shift(1'b1, 1'b0, 1'b1); check("R3 walk a", q, exp_q);
    do_shift(1'b1, 1'b1, 1'b0); check("R3 walk b", q, exp_q);
    check("R3 pattern", q, 4'b0100);
  endtask

  task automatic t_left_fill;
    for (int k = 0; k < 4; k++) do_shift(1'b1, 1'b0, 1'b1);
    check("R4 fill ones", q, 4'b1111);
    for (int k = 0; k < 4; k++) do_shift(1'b1, 1'b1, 1'b0);
    check("R8 right input ignored in left mode", q, 4'b0000);
  endtask

  task automatic t_hold;
    do_shift(1'b0, 1'b1, 1'b0);
    do_shift(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      dir_mode = k[0]; ser_right_in = ~k[1]; ser_left_in = k[1];
    end
    @(negedge clk);
    check("R5 hold", q, 4'b0010);
  endtask

  task automatic t_mode_switch;
    do_shift(1'b0, 1'b1, 1'b0); check("R6 right step", q, exp_q);
    @(negedge clk); dir_mode = 1'b1;
    @(negedge clk); dir_mode = 1'b0;
    check("R6 mode toggle without strobe", q, exp_q);
    do_shift(1'b1, 1'b0, 1'b1); check("R6 left step after switch", q, exp_q);
    do_shift(1'b0, 1'b0, 1'b0); check("R6 right step after switch", q, exp_q);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_q = '0;
    #(CLK_PERIOD/4);
    check("R7 reset state", q, '0);
    t_reset_release();
    t_right_walk();
    t_right_fill();
    t_left_walk();
    t_left_fill();
    t_hold();
    t_mode_switch();
    t_reset_release();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule